// File: doc/BRIEF.md
# Timing-Wheel Buffer Timeout Scheduler

This block keeps a timeout for every transmit channel whose buffer has only been partly filled. Timeouts live in a circular bitmap called the wheel. The wheel has one row per timer tick and one bit column per channel. A row pointer marks the row that the next tick inspects. To arm a channel, the block sets one bit in the row that lies the channel's configured delay ahead of the pointer. For each channel it also stores the row index it used, plus an armed flag. A cancel or a re-arm can therefore clear the old bit directly, with no search.

On each periodic tick the scheduler copies the current row into a drain register and clears that row in the wheel. It then reports the expired channels one at a time on an output stream that carries a channel number and uses a valid/ready handshake. The pointer moves forward one row only after the last of those channels has been accepted. Ticks that arrive during a drain are counted and handled afterwards, so none are lost. Padding, descriptor handling and cell transmission are done elsewhere. This block only signals expiry.

The control logic has two states:
- `ST_IDLE` waits for a tick. If a tick is present and the current row is empty, it advances the pointer (transition *skip*). If the row holds set bits, it moves to `ST_DRAIN` (transition *load*).
- `ST_DRAIN` presents the lowest-numbered channel still left in the drain register. When the last channel is accepted, it returns to `ST_IDLE` and advances the pointer (transition *finish*). Any other accepted channel keeps it in `ST_DRAIN` (transition *next*).

Top module: `tmo_wheel`

## Requirements
- R1: After reset the pointer is at row 0, the wheel is empty, no channel is armed and `exp_vld` is 0.
- R2: A start for an enabled channel with delay d, issued in `ST_IDLE` with no tick that cycle, sets the bit in row (pointer + d) mod DEPTH. The channel therefore expires on the (d+1)-th tick after the start. A delay of 0 expires on the very next tick.
- R3: A start for a channel whose enable bit `cfg_en[ch]` is 0 is ignored: no event ever appears for it.
- R4: A cancel clears the armed channel's bit, so no event appears for it. A cancel for a channel that is not armed changes nothing, and other armed channels still expire on time.
- R5: A start for a channel that is already armed first removes its old bit. Only the new deadline produces an event, and it produces exactly one.
- R6: All channels that expire in the same row are emitted on `exp_ch` one per accepted cycle, in ascending channel number.
- R7: While `exp_vld` is 1 and `exp_rdy` is 0, `exp_vld` stays 1 and `exp_ch` stays unchanged.
- R8: The pointer does not move while a row is draining. Ticks that arrive during a drain are counted, up to 2^PEND_W-1, and then processed one per cycle after the drain, each scanning the next row.
- R9: The pointer wraps from row DEPTH-1 to row 0. The largest delay, DEPTH-1, expires on the DEPTH-th tick.
- R10: A start issued during a drain, or in the cycle a tick is taken, measures its delay from the row after the current one. A delay of 0 then expires on the first tick after the drain.
- R11: A tick that finds the current row empty produces no event and advances the pointer by exactly one row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_vld | input | 1 | Arm request strobe |
| start_ch | input | CW | Channel to arm |
| cancel_vld | input | 1 | Cancel request strobe |
| cancel_ch | input | CW | Channel to disarm |
| tick | input | 1 | Periodic timer tick, one cycle per period |
| cfg_en | input | NUM_CH | Per-channel timeout enable |
| cfg_dly | input | NUM_CH*PW | Per-channel delay in ticks; channel c occupies bits [c*PW +: PW] |
| exp_vld | output | 1 | An expired channel is being presented |
| exp_ch | output | CW | Number of the expired channel |
| exp_rdy | input | 1 | Consumer accepts the presented channel |

## Verification
The bench builds the block with DEPTH = 8 and NUM_CH = 6. The shallow wheel lets the longest delay and the pointer wrap be reached in a few ticks. The channel count, which is not a power of two, exercises the ascending selection across a partly used column space. With PEND_W left at 4, the bench can queue several ticks behind a row that is held by backpressure, and it can check that a start issued during a drain is measured from the following row.

// File: rtl/tmo_wheel_pkg.sv
package tmo_wheel_pkg;
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_DRAIN = 1'b1
    } tw_state_e;
endpackage

// File: rtl/tmo_first_set.sv
// Returns the index of the lowest set bit in a vector.
module tmo_first_set #(
    parameter int W  = 8,
    localparam int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic          any
);
    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
        any = |vec;
    end
endmodule

// File: rtl/tmo_row_table.sv
// Bitmap storage for the wheel. Clears are applied first, then the set, so a set wins.
module tmo_row_table #(
    parameter int ROWS = 64,
    parameter int COLS = 16,
    localparam int RW = $clog2(ROWS),
    localparam int CW = (COLS > 1) ? $clog2(COLS) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [RW-1:0]   rd_idx,
    output logic [COLS-1:0] rd_row,
    input  logic            wipe_en,
    input  logic [RW-1:0]   wipe_idx,
    input  logic            clr_a_en,
    input  logic [RW-1:0]   clr_a_row,
    input  logic [CW-1:0]   clr_a_col,
    input  logic            clr_b_en,
    input  logic [RW-1:0]   clr_b_row,
    input  logic [CW-1:0]   clr_b_col,
    input  logic            set_en,
    input  logic [RW-1:0]   set_row,
    input  logic [CW-1:0]   set_col
);
    logic [ROWS-1:0][COLS-1:0] tbl_q;
    logic [ROWS-1:0][COLS-1:0] tbl_d;

    always_comb begin
        tbl_d = tbl_q;
        if (wipe_en)  tbl_d[wipe_idx] = '0;
        if (clr_a_en) tbl_d[clr_a_row][clr_a_col] = 1'b0;
        if (clr_b_en) tbl_d[clr_b_row][clr_b_col] = 1'b0;
        if (set_en)   tbl_d[set_row][set_col] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end

    assign rd_row = tbl_q[rd_idx];
endmodule

// File: rtl/tmo_wheel.sv
module tmo_wheel
    import tmo_wheel_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int DEPTH  = 64,
    parameter int PEND_W = 4,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_vld,
    input  logic [CW-1:0]      start_ch,
    input  logic               cancel_vld,
    input  logic [CW-1:0]      cancel_ch,
    input  logic               tick,
    input  logic [NUM_CH-1:0]  cfg_en,
    input  logic [NUM_CH*PW-1:0] cfg_dly,
    output logic               exp_vld,
    output logic [CW-1:0]      exp_ch,
    input  logic               exp_rdy
);
    tw_state_e             state, state_n;
    logic [PW-1:0]         ptr;
    logic [PEND_W-1:0]     pend, pend_n;
    logic [NUM_CH-1:0]     drain_mask, rest_mask;
    logic [NUM_CH-1:0]     armed;
    logic [PW-1:0]         arm_row [NUM_CH];
    logic [NUM_CH-1:0]     cur_row;
    logic [CW-1:0]         low_idx;
    logic                  low_any;

    logic                  scan_now, row_hit, last_pick, ptr_adv;
    logic [PW-1:0]         base_row, tgt_row, dly_sel;
    logic                  start_ok, rearm_hit, cancel_hit;

    // Decode of the request side
    assign scan_now   = (state == ST_IDLE) && (tick || (pend != '0));
    assign row_hit    = |cur_row;
    assign base_row   = (scan_now || state == ST_DRAIN) ? ptr + PW'(1) : ptr;
    assign dly_sel    = cfg_dly[int'(start_ch)*PW +: PW];
    assign tgt_row    = base_row + dly_sel;
    assign start_ok   = start_vld && (int'(start_ch) < NUM_CH) && cfg_en[start_ch];
    assign rearm_hit  = start_ok && armed[start_ch];
    assign cancel_hit = cancel_vld && (int'(cancel_ch) < NUM_CH) && armed[cancel_ch];

    always_comb begin
        rest_mask = drain_mask;
        rest_mask[low_idx] = 1'b0;
    end
    assign last_pick = (rest_mask == '0);
    assign ptr_adv   = (scan_now && !row_hit) ||
                       (state == ST_DRAIN && exp_rdy && last_pick);

    tmo_row_table #(.ROWS(DEPTH), .COLS(NUM_CH)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (ptr),
        .rd_row    (cur_row),
        .wipe_en   (scan_now && row_hit),
        .wipe_idx  (ptr),
        .clr_a_en  (cancel_hit),
        .clr_a_row (arm_row[cancel_ch]),
        .clr_a_col (cancel_ch),
        .clr_b_en  (rearm_hit),
        .clr_b_row (arm_row[start_ch]),
        .clr_b_col (start_ch),
        .set_en    (start_ok),
        .set_row   (tgt_row),
        .set_col   (start_ch)
    );

    tmo_first_set #(.W(NUM_CH)) u_pick (
        .vec (drain_mask),
        .idx (low_idx),
        .any (low_any)
    );

    // Next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:  if (scan_now && row_hit) state_n = ST_DRAIN;            // load
            ST_DRAIN: if (exp_rdy && last_pick) state_n = ST_IDLE;            // finish
            default:  state_n = ST_IDLE;
        endcase
    end

    always_comb begin
        pend_n = pend;
        if (tick && !scan_now) begin
            if (pend != '1) pend_n = pend + PEND_W'(1);
        end else if (!tick && scan_now) begin
            pend_n = pend - PEND_W'(1);
        end
    end

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            ptr        <= '0;
            pend       <= '0;
            drain_mask <= '0;
        end else begin
            state <= state_n;
            pend  <= pend_n;
            if (ptr_adv) ptr <= ptr + PW'(1);
            if (scan_now && row_hit)            drain_mask <= cur_row;
            else if (state == ST_DRAIN && exp_rdy) drain_mask <= rest_mask;
        end
    end

    // Per-channel armed flag and stored row
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                armed[c]   <= 1'b0;
                arm_row[c] <= '0;
            end else if (start_ok && int'(start_ch) == c) begin
                armed[c]   <= 1'b1;
                arm_row[c] <= tgt_row;
            end else if ((cancel_hit && int'(cancel_ch) == c) ||
                         (scan_now && cur_row[c])) begin
                armed[c]   <= 1'b0;
            end
        end
    end

    // Output process
    always_comb begin
        unique case (state)
            ST_DRAIN: begin exp_vld = low_any; exp_ch = low_idx; end
            default:  begin exp_vld = 1'b0;    exp_ch = '0;      end
        endcase
    end
endmodule

// File: rtl/tmo_wheel_chk.sv
module tmo_wheel_chk #(
    parameter int NUM_CH = 16,
    parameter int DEPTH  = 64,
    parameter int PEND_W = 4,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              exp_vld,
    input logic              exp_rdy,
    input logic [CW-1:0]     exp_ch,
    input logic [PW-1:0]     ptr,
    input logic [PEND_W-1:0] pend
);
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        exp_vld && !exp_rdy |=> exp_vld && $stable(exp_ch));

    p_ascending_r6: assert property (@(posedge clk) disable iff (!rst_n)
        exp_vld && exp_rdy |=> !exp_vld || (exp_ch > $past(exp_ch)));

    p_chan_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        exp_vld |-> int'(exp_ch) < NUM_CH);

    p_ptr_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        exp_vld && !exp_rdy |=> $stable(ptr));

    p_tick_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tick && exp_vld |=> pend != '0);

    p_ptr_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ptr != $past(ptr) |-> ptr == $past(ptr) + PW'(1));
endmodule

bind tmo_wheel tmo_wheel_chk #(.NUM_CH(NUM_CH), .DEPTH(DEPTH), .PEND_W(PEND_W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .exp_vld (exp_vld),
    .exp_rdy (exp_rdy),
    .exp_ch  (exp_ch),
    .ptr     (ptr),
    .pend    (pend)
);

// File: tb/tmo_wheel_tb_top.sv
`timescale 1ns/1ps
module tmo_wheel_tb_top;
    localparam int NUM_CH = 6;
    localparam int DEPTH  = 8;
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(NUM_CH);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_vld = 1'b0, cancel_vld = 1'b0, tick = 1'b0, exp_rdy = 1'b1;
    logic [CW-1:0] start_ch = '0, cancel_ch = '0;
    logic [NUM_CH-1:0] cfg_en = '1;
    logic [NUM_CH*PW-1:0] cfg_dly = '0;
    logic exp_vld;
    logic [CW-1:0] exp_ch;

    int n_chk = 0, n_fail = 0;
    int ev_ch [32];
    int ev_n = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    tmo_wheel #(.NUM_CH(NUM_CH), .DEPTH(DEPTH), .PEND_W(4)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .start_vld(start_vld), .start_ch(start_ch),
        .cancel_vld(cancel_vld), .cancel_ch(cancel_ch),
        .tick(tick), .cfg_en(cfg_en), .cfg_dly(cfg_dly),
        .exp_vld(exp_vld), .exp_ch(exp_ch), .exp_rdy(exp_rdy)
    );

    // Event logger: samples 2 ns after the falling edge
    always @(negedge clk) begin
        #2;
        if (rst_n && exp_vld && exp_rdy) begin
            if (ev_n < 32) ev_ch[ev_n] = int'(exp_ch);
            ev_n++;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_cfg(input int ch, input bit en, input int dly);
        cfg_en[ch] = en;
        cfg_dly[ch*PW +: PW] = PW'(dly);
    endtask

    task automatic arm(input int ch, input int dly);
        @(negedge clk);
        cfg_dly[ch*PW +: PW] = PW'(dly);
        start_vld = 1'b1; start_ch = CW'(ch);
        @(negedge clk);
        start_vld = 1'b0;
    endtask

    task automatic disarm(input int ch);
        @(negedge clk);
        cancel_vld = 1'b1; cancel_ch = CW'(ch);
        @(negedge clk);
        cancel_vld = 1'b0;
    endtask

    task automatic tick_raw();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask

    task automatic tick_n(input int n);
        for (int i = 0; i < n; i++) begin
            tick_raw();
            cycles(4);
        end
    endtask

    task automatic t_reset();
        #2;
        check(exp_vld == 1'b0, "R1 idle after reset", int'(exp_vld), 0);
        ev_n = 0;
        tick_n(DEPTH);
        check(ev_n == 0, "R1 empty wheel gives no events", ev_n, 0);
    endtask

    task automatic t_basic();
        ev_n = 0;
        arm(2, 3);
        tick_n(3);
        check(ev_n == 0, "R2/R11 no event before deadline", ev_n, 0);
        tick_n(1);
        check(ev_n == 1, "R2 one event at 4th tick", ev_n, 1);
        check(ev_ch[0] == 2, "R2 expired channel", ev_ch[0], 2);
        ev_n = 0;
        arm(5, 0);
        tick_n(1);
        check(ev_n == 1 && ev_ch[0] == 5, "R2 zero delay expires on next tick", ev_ch[0], 5);
    endtask

    task automatic t_disabled();
        ev_n = 0;
        set_cfg(4, 1'b0, 1);
        arm(4, 1);
        tick_n(3);
        check(ev_n == 0, "R3 disabled channel ignored", ev_n, 0);
        set_cfg(4, 1'b1, 1);
    endtask

    task automatic t_cancel();
        ev_n = 0;
        arm(1, 2);
        arm(3, 2);
        disarm(1);
        disarm(5);
        tick_n(3);
        check(ev_n == 1, "R4 only uncancelled channel expires", ev_n, 1);
        check(ev_ch[0] == 3, "R4 surviving channel", ev_ch[0], 3);
    endtask

    task automatic t_rearm();
        ev_n = 0;
        arm(0, 1);
        arm(0, 4);
        tick_n(2);
        check(ev_n == 0, "R5 old deadline removed", ev_n, 0);
        tick_n(3);
        check(ev_n == 1 && ev_ch[0] == 0, "R5 single event at new deadline", ev_n, 1);
    endtask

    task automatic t_order_hold();
        ev_n = 0;
        arm(5, 2);
        arm(1, 2);
        arm(3, 2);
        tick_n(2);
        exp_rdy = 1'b0;
        tick_raw();
        #2;
        check(exp_vld == 1'b1 && exp_ch == 1, "R6 lowest channel first", int'(exp_ch), 1);
        cycles(3);
        #2;
        check(exp_vld == 1'b1 && exp_ch == 1, "R7 held under backpressure", int'(exp_ch), 1);
        check(ev_n == 0, "R7 no handshake while not ready", ev_n, 0);
        exp_rdy = 1'b1;
        cycles(5);
        check(ev_n == 3, "R6 all row members emitted", ev_n, 3);
        check(ev_ch[0] == 1 && ev_ch[1] == 3 && ev_ch[2] == 5, "R6 ascending order",
              ev_ch[0]*100 + ev_ch[1]*10 + ev_ch[2], 135);
    endtask

    task automatic t_pending();
        ev_n = 0;
        arm(2, 0);
        arm(4, 1);
        exp_rdy = 1'b0;
        tick_raw();
        tick_raw();
        cycles(2);
        exp_rdy = 1'b1;
        cycles(6);
        check(ev_n == 2, "R8 tick during drain kept", ev_n, 2);
        check(ev_ch[0] == 2 && ev_ch[1] == 4, "R8 pending tick scans next row",
              ev_ch[0]*10 + ev_ch[1], 24);
    endtask

    task automatic t_wrap();
        ev_n = 0;
        arm(3, DEPTH - 1);
        tick_n(DEPTH - 1);
        check(ev_n == 0, "R9/R11 no early event across wrap", ev_n, 0);
        tick_n(1);
        check(ev_n == 1 && ev_ch[0] == 3, "R9 max delay expires at DEPTH-th tick", ev_n, 1);
    endtask

    task automatic t_drain_arm();
        ev_n = 0;
        arm(1, 0);
        exp_rdy = 1'b0;
        tick_raw();
        arm(2, 0);
        exp_rdy = 1'b1;
        cycles(4);
        check(ev_n == 1 && ev_ch[0] == 1, "R10 only drained channel so far", ev_n, 1);
        tick_n(1);
        check(ev_n == 2 && ev_ch[1] == 2, "R10 arm during drain uses next row", ev_n, 2);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        cycles(3);
        rst_n = 1'b1;
        cycles(1);
        t_reset();
        t_basic();
        t_disabled();
        t_cancel();
        t_rearm();
        t_order_hold();
        t_pending();
        t_wrap();
        t_drain_arm();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule